// File: doc/BRIEF.md
# Multi-Frame Receive Buffer with Word Readout

This block sits behind a receive MAC and holds complete incoming frames until a host drains them. Frames arrive as a byte stream with a valid strobe and an end-of-frame marker. Each accepted frame is written into one of `NUM_SLOTS` fixed-size slots that are used as a circular queue. A stored slot holds three things in order: a 16-bit length word, the frame bytes, and an Ethernet FCS that the block computes itself. Any bytes left over in the last 32-bit word are written as zero.

The host reads the oldest frame one 32-bit word at a time through a read strobe. The block moves through the slot by itself. Once the last word of a frame has been read, it releases the slot and moves on to the next one. A held-frame count is exposed, and the block pulses an interrupt each time a frame is stored. A FIFO-reset input empties the queue.

The input stream must leave at least 8 idle cycles after each end-of-frame byte. The block uses those cycles to write the trailer, the padding and the length word. A byte that arrives during those cycles is ignored.

Top module: `rx_frame_buffer`

## Requirements
- R1: A frame whose first byte arrives while `rx_en` is low is discarded entirely. The count does not change and no interrupt is raised.
- R2: A frame whose first byte arrives while `frame_count` equals `NUM_SLOTS` is discarded. The count stays at `NUM_SLOTS` and no interrupt is raised.
- R3: An accepted frame is placed in slot (head + count) mod `NUM_SLOTS`, and the count rises by one. Frames are therefore read back in arrival order, including across the wrap of the slot ring.
- R4: Byte 0 of a slot holds the low byte of L and byte 1 holds the high byte, where L is the stored frame size plus 6. The frame bytes follow from byte 2 onward.
- R5: The FCS is placed directly after the frame bytes, least significant byte first. It is computed over the stored bytes with the reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion. For the bytes "123456789" it is 0xCBF43926.
- R6: The bytes after the FCS, up to the next 4-byte boundary, read as zero.
- R7: Each `rd_req` cycle places the next four bytes of the head slot on `rd_data` after that clock edge. The lowest-addressed byte appears in bits 7:0.
- R8: After a read, the read offset advances by 4. When the new offset reaches or passes L, the offset returns to 0, the head advances modulo `NUM_SLOTS` and the count drops by one.
- R9: A read while the count is zero puts 0 on `rd_data` and changes neither the count nor the read position.
- R10: A `fifo_rst` cycle clears the count and the read offset and leaves the head where it is. It also abandons any frame that is partly received: the rest of that frame is skipped and never counted.
- R11: `rx_irq` is high for exactly one cycle per stored frame. It rises on the same edge at which the count goes up.
- R12: A frame longer than `SLOT_BYTES`-6 bytes keeps only its first `SLOT_BYTES`-6 bytes. L and the FCS are computed over the kept bytes.
- R13: After reset, `frame_count` is 0, `rx_irq` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled on the first byte of each frame |
| fifo_rst | input | 1 | Single-cycle request that empties the queue |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| rd_req | input | 1 | Host word-read strobe |
| rd_data | output | 32 | Word returned by the last read |
| frame_count | output | clog2(NUM_SLOTS+1) | Number of complete frames held |
| rx_irq | output | 1 | One-cycle pulse for each stored frame |

## Verification
The bench builds the buffer with `NUM_SLOTS`=5 and `SLOT_BYTES`=64. Five slots let a handful of frames fill the ring, reach the drop condition and wrap the head and write positions many times during the random phase. The 64-byte slots put the truncation limit at 58 bytes, so frames just below, at and above that limit are cheap to send. Frame sizes 1 to 8 cover every padding length. A nine-byte frame carrying the standard check string pins the FCS to a known constant.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DATA,
    WS_TRAIL,
    WS_PAD,
    WS_HDR,
    WS_SKIP
  } wr_state_e;

  localparam logic [31:0] FCS_POLY = 32'hEDB8_8320;

  // One byte of a reflected CRC-32, processed bit by bit
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ FCS_POLY) : (r >> 1);
    end
    return r;
  endfunction

  // (a + b) mod n for a, b < n
  function automatic logic [15:0] ring_sum(input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] n);
    logic [15:0] s;
    s = a + b;
    return (s >= n) ? (s - n) : s;
  endfunction

  function automatic logic [31:0] word_addr(input logic [15:0] slot, input logic [15:0] word,
                                            input int words_per_slot);
    return (32'(slot) * 32'(words_per_slot)) + 32'(word);
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] idx);
    return 4'b0001 << idx;
  endfunction

endpackage

// File: rtl/rxb_slot_mem.sv
module rxb_slot_mem #(
  parameter int DEPTH = 992,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic [3:0]    we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata,
  input  logic [AW-1:0] hdr_addr,
  output logic [15:0]   hdr_data
);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[8*g +: 8];
    end

    assign rdata[8*g +: 8] = mem[raddr];

    if (g < 2) begin : g_hdr
      assign hdr_data[8*g +: 8] = mem[hdr_addr];
    end
  end

endmodule

// File: rtl/rxb_crc32.sv
module rxb_crc32 import rxb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        step,
  input  logic [7:0]  data,
  output logic [31:0] fcs
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= 32'hFFFF_FFFF;
    else if (start) crc_q <= crc32_step(32'hFFFF_FFFF, data);
    else if (step)  crc_q <= crc32_step(crc_q, data);
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/rxb_writer.sv
module rxb_writer import rxb_pkg::*; #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 128
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rx_en,
  input  logic                               fifo_rst,
  input  logic                               in_valid,
  input  logic [7:0]                         in_data,
  input  logic                               in_last,
  input  logic [$clog2(NUM_SLOTS)-1:0]       head,
  input  logic [$clog2(NUM_SLOTS+1)-1:0]     count,
  output logic [3:0]                         mem_we,
  output logic [$clog2(NUM_SLOTS*(SLOT_BYTES/4))-1:0] mem_waddr,
  output logic [31:0]                        mem_wdata,
  output logic                               accept,
  output logic                               commit
);

  localparam int SLOT_WORDS = SLOT_BYTES / 4;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int CNT_W      = $clog2(NUM_SLOTS + 1);
  localparam int AW         = $clog2(NUM_SLOTS * SLOT_WORDS);
  localparam logic [15:0] MAX_FRAME = 16'(SLOT_BYTES - 6);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);

  wr_state_e          st_q, st_d;
  logic [15:0]        pos_q, pos_d;
  logic [15:0]        fsz_q, fsz_d;
  logic [1:0]         k_q, k_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;

  logic [SLOT_W-1:0]  tgt, wslot;
  logic [15:0]        wpos, hdr_len;
  logic [7:0]         wbyte;
  logic               hdr_wr, crc_start, crc_step;
  logic [31:0]        fcs;

  assign tgt     = SLOT_W'(ring_sum(16'(head), 16'(count), 16'(NUM_SLOTS)));
  assign hdr_len = fsz_q + 16'd6;

  rxb_crc32 crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (crc_start),
    .step  (crc_step),
    .data  (in_data),
    .fcs   (fcs)
  );

  always_comb begin
    st_d = st_q; pos_d = pos_q; fsz_d = fsz_q; k_d = k_q; slot_d = slot_q;
    wslot = slot_q; wpos = pos_q; mem_we = 4'b0000; wbyte = 8'h00; hdr_wr = 1'b0;
    crc_start = 1'b0; crc_step = 1'b0; accept = 1'b0; commit = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (in_valid) begin
          if (rx_en && !fifo_rst && (count < FULL)) begin
            accept    = 1'b1;
            slot_d    = tgt;
            wslot     = tgt;
            wpos      = 16'd2;
            mem_we    = 4'b0100;
            wbyte     = in_data;
            crc_start = 1'b1;
            fsz_d     = 16'd1;
            pos_d     = 16'd3;
            k_d       = 2'd0;
            st_d      = in_last ? WS_TRAIL : WS_DATA;
          end else if (!in_last) begin
            st_d = WS_SKIP;
          end
        end
      end
      WS_DATA: begin
        if (fifo_rst) begin
          st_d = (in_valid && in_last) ? WS_IDLE : WS_SKIP;
        end else if (in_valid) begin
          if (fsz_q < MAX_FRAME) begin
            mem_we   = lane_mask(pos_q[1:0]);
            wbyte    = in_data;
            crc_step = 1'b1;
            fsz_d    = fsz_q + 16'd1;
            pos_d    = pos_q + 16'd1;
          end
          if (in_last) begin
            st_d = WS_TRAIL;
            k_d  = 2'd0;
          end
        end
      end
      WS_TRAIL: begin
        if (fifo_rst) begin
          st_d = WS_IDLE;
        end else begin
          mem_we = lane_mask(pos_q[1:0]);
          wbyte  = fcs[{k_q, 3'b000} +: 8];
          pos_d  = pos_q + 16'd1;
          k_d    = k_q + 2'd1;
          if (k_q == 2'd3) st_d = (pos_q[1:0] == 2'd3) ? WS_HDR : WS_PAD;
        end
      end
      WS_PAD: begin
        if (fifo_rst) begin
          st_d = WS_IDLE;
        end else begin
          mem_we = lane_mask(pos_q[1:0]);
          wbyte  = 8'h00;
          pos_d  = pos_q + 16'd1;
          if (pos_q[1:0] == 2'd3) st_d = WS_HDR;
        end
      end
      WS_HDR: begin
        st_d = WS_IDLE;
        if (!fifo_rst) begin
          commit = 1'b1;
          hdr_wr = 1'b1;
          wpos   = 16'd0;
          mem_we = 4'b0011;
        end
      end
      WS_SKIP: begin
        if (in_valid && in_last) st_d = WS_IDLE;
      end
      default: st_d = WS_IDLE;
    endcase
  end

  assign mem_wdata = hdr_wr ? {16'h0000, hdr_len} : {4{wbyte}};
  assign mem_waddr = AW'(word_addr(16'(wslot), wpos >> 2, SLOT_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      pos_q  <= '0;
      fsz_q  <= '0;
      k_q    <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      fsz_q  <= fsz_d;
      k_q    <= k_d;
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/rxb_reader.sv
module rxb_reader import rxb_pkg::*; #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 128
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        rd_req,
  input  logic                                        fifo_rst,
  input  logic [$clog2(NUM_SLOTS+1)-1:0]              count,
  input  logic [31:0]                                 word_in,
  input  logic [15:0]                                 hdr_len,
  output logic [$clog2(NUM_SLOTS*(SLOT_BYTES/4))-1:0] raddr,
  output logic [$clog2(NUM_SLOTS*(SLOT_BYTES/4))-1:0] hdr_addr,
  output logic [31:0]                                 rd_data,
  output logic                                        pop,
  output logic [$clog2(NUM_SLOTS)-1:0]                head
);

  localparam int SLOT_WORDS = SLOT_BYTES / 4;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int WOFF_W     = $clog2(SLOT_WORDS);
  localparam int AW         = $clog2(NUM_SLOTS * SLOT_WORDS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] head_q;
  logic [WOFF_W-1:0] word_q;
  logic              serve, last_word;

  assign serve     = rd_req && (count != '0) && !fifo_rst;
  assign last_word = ((16'(word_q) + 16'd1) << 2) >= hdr_len;
  assign pop       = serve && last_word;
  assign head      = head_q;
  assign raddr     = AW'(word_addr(16'(head_q), 16'(word_q), SLOT_WORDS));
  assign hdr_addr  = AW'(word_addr(16'(head_q), 16'd0, SLOT_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      word_q  <= '0;
      rd_data <= '0;
    end else begin
      if (rd_req) rd_data <= serve ? word_in : 32'd0;
      if (fifo_rst) begin
        word_q <= '0;
      end else if (serve) begin
        if (last_word) begin
          word_q <= '0;
          head_q <= (head_q == LAST_SLOT) ? '0 : head_q + 1'b1;
        end else begin
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer #(
  parameter int NUM_SLOTS  = 31,
  parameter int SLOT_BYTES = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_en,
  input  logic                           fifo_rst,
  input  logic                           in_valid,
  input  logic [7:0]                     in_data,
  input  logic                           in_last,
  input  logic                           rd_req,
  output logic [31:0]                    rd_data,
  output logic [$clog2(NUM_SLOTS+1)-1:0] frame_count,
  output logic                           rx_irq
);

  localparam int SLOT_WORDS = SLOT_BYTES / 4;
  localparam int DEPTH      = NUM_SLOTS * SLOT_WORDS;
  localparam int AW         = $clog2(DEPTH);
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int CNT_W      = $clog2(NUM_SLOTS + 1);

  logic [CNT_W-1:0]  count_q;
  logic              irq_q;
  logic              commit, pop, accept;
  logic [SLOT_W-1:0] head;
  logic [3:0]        mem_we;
  logic [AW-1:0]     mem_waddr, raddr, hdr_addr;
  logic [31:0]       mem_wdata, word_rd;
  logic [15:0]       hdr_len;

  rxb_writer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) wr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .fifo_rst  (fifo_rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .head      (head),
    .count     (count_q),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .accept    (accept),
    .commit    (commit)
  );

  rxb_slot_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk      (clk),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata),
    .raddr    (raddr),
    .rdata    (word_rd),
    .hdr_addr (hdr_addr),
    .hdr_data (hdr_len)
  );

  rxb_reader #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .fifo_rst (fifo_rst),
    .count    (count_q),
    .word_in  (word_rd),
    .hdr_len  (hdr_len),
    .raddr    (raddr),
    .hdr_addr (hdr_addr),
    .rd_data  (rd_data),
    .pop      (pop),
    .head     (head)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= commit;
      if (fifo_rst) count_q <= '0;
      else          count_q <= count_q + CNT_W'(commit) - CNT_W'(pop);
    end
  end

  assign frame_count = count_q;
  assign rx_irq      = irq_q;

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int NUM_SLOTS = 31
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           rd_req,
  input logic                           rx_irq,
  input logic                           fifo_rst,
  input logic [31:0]                    rd_data,
  input logic [$clog2(NUM_SLOTS+1)-1:0] count,
  input logic                           commit,
  input logic                           pop,
  input logic                           accept
);

  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);

  a_r2_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  a_r2_accept_room: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (count < FULL));

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  a_r11_irq_with_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ((count + CNT_W'($past(pop))) == ($past(count) + 1'b1)));

  a_r10_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> ((count == '0) && !rx_irq));

  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (count == '0) && !commit) |=> ((count == '0) && (rd_data == 32'd0)));

  a_r8_pop_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

bind rx_frame_buffer rxb_checker #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rx_irq   (rx_irq),
  .fifo_rst (fifo_rst),
  .rd_data  (rd_data),
  .count    (count_q),
  .commit   (commit),
  .pop      (pop),
  .accept   (accept)
);

// File: tb/rx_frame_buffer_tb_top.sv
module rx_frame_buffer_tb_top;

  localparam int NS   = 5;
  localparam int SB   = 64;
  localparam int SW   = SB / 4;
  localparam int MAXF = SB - 6;
  localparam int CW   = $clog2(NS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          fifo_rst = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_last = 1'b0;
  logic          rd_req = 1'b0;
  logic [31:0]   rd_data;
  logic [CW-1:0] frame_count;
  logic          rx_irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int exp_irq = 0;
  bit done = 1'b0;

  logic [7:0]  fb [128];
  logic [31:0] m_words [NS][SW];
  int          m_len [NS];
  int          m_head = 0;
  int          m_cnt = 0;
  int          m_off = 0;
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  rx_frame_buffer #(.NUM_SLOTS(NS), .SLOT_BYTES(SB)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .fifo_rst    (fifo_rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .rd_req      (rd_req),
    .rd_data     (rd_data),
    .frame_count (frame_count),
    .rx_irq      (rx_irq)
  );

  always @(posedge clk) if (rst_n && rx_irq) irq_seen <= irq_seen + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Bit-serial FCS over the first n bytes of fb
  function automatic logic [31:0] bench_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        bit fbk;
        fbk = c[0] ^ fb[i][j];
        c = c >> 1;
        if (fbk) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic model_store(input int len);
    logic [7:0]  eb [SB];
    logic [31:0] f;
    int slot, kept, l;
    slot = (m_head + m_cnt) % NS;
    kept = (len > MAXF) ? MAXF : len;
    l    = kept + 6;
    for (int i = 0; i < SB; i++) eb[i] = 8'h00;
    eb[0] = l[7:0];
    eb[1] = l[15:8];
    for (int i = 0; i < kept; i++) eb[2 + i] = fb[i];
    f = bench_fcs(kept);
    for (int j = 0; j < 4; j++) eb[2 + kept + j] = f[8*j +: 8];
    for (int w = 0; w < SW; w++) m_words[slot][w] = {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};
    m_len[slot] = l;
    m_cnt++;
    exp_irq++;
  endtask

  // Drives one frame from fb; abort_at >= 0 puts a fifo_rst cycle before that byte
  task automatic send_frame(input int len, input int abort_at, input string tag);
    bit will_store;
    will_store = rx_en && (m_cnt < NS);
    for (int i = 0; i < len; i++) begin
      if (i == abort_at) begin
        in_valid = 1'b0;
        fifo_rst = 1'b1;
        @(negedge clk);
        fifo_rst = 1'b0;
      end
      in_valid = 1'b1;
      in_data  = fb[i];
      in_last  = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (10) @(negedge clk);
    if (abort_at >= 0 && abort_at < len) begin
      m_cnt = 0;
      m_off = 0;
    end else if (will_store) begin
      model_store(len);
    end
    chk(frame_count == CW'(m_cnt), tag, 32'(frame_count), 32'(m_cnt));
    chk(irq_seen == exp_irq, "R11 irq pulses", irq_seen, exp_irq);
  endtask

  task automatic fill_random(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom_range(0, 255));
  endtask

  task automatic do_read(input string tag);
    logic [31:0] exp;
    if (m_cnt == 0) begin
      exp = 32'd0;
    end else begin
      exp = m_words[m_head][m_off];
      m_off++;
      if (m_off * 4 >= m_len[m_head]) begin
        m_off  = 0;
        m_head = (m_head + 1) % NS;
        m_cnt--;
      end
    end
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    last_rd = rd_data;
    chk(rd_data == exp, tag, rd_data, exp);
    chk(frame_count == CW'(m_cnt), "R8 count after read", 32'(frame_count), 32'(m_cnt));
  endtask

  task automatic drain(input string tag);
    while (m_cnt != 0) do_read(tag);
  endtask

  task automatic pulse_fifo_rst();
    fifo_rst = 1'b1;
    @(negedge clk);
    fifo_rst = 1'b0;
    m_cnt = 0;
    m_off = 0;
    chk(frame_count == '0, "R10 count cleared", 32'(frame_count), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd13579));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13 reset state
    chk(frame_count == '0, "R13 count after reset", 32'(frame_count), 32'd0);
    chk(rx_irq == 1'b0, "R13 irq after reset", 32'(rx_irq), 32'd0);
    chk(rd_data == 32'd0, "R13 rd_data after reset", rd_data, 32'd0);

    // R9 empty read
    do_read("R9 empty read");

    // R1 refused while disabled
    fill_random(10);
    send_frame(10, -1, "R1 refused frame");

    // R4 R5 R6 R7 known string
    rx_en = 1'b1;
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    send_frame(9, -1, "R3 count after store");
    do_read("R7 word0");
    chk(last_rd == 32'h3231_000F, "R4 length prefix", last_rd, 32'h3231_000F);
    do_read("R7 word1");
    chk(last_rd == 32'h3635_3433, "R7 byte order", last_rd, 32'h3635_3433);
    do_read("R7 word2");
    chk(last_rd == 32'h2639_3837, "R5 fcs low byte", last_rd, 32'h2639_3837);
    do_read("R7 word3");
    chk(last_rd == 32'h00CB_F439, "R6 fcs and pad", last_rd, 32'h00CB_F439);

    // R6 every padding length
    for (int n = 1; n <= 8; n++) begin
      fill_random(n);
      send_frame(n, -1, "R3 count small frame");
      drain("R6 small frame readout");
    end

    // R2 full ring drops the extra frame
    for (int f = 0; f < NS + 1; f++) begin
      fill_random(12 + f);
      send_frame(12 + f, -1, "R2 count at full");
    end
    drain("R3 order after full");

    // R3 wrap
    for (int f = 0; f < 3; f++) begin fill_random(20); send_frame(20, -1, "R3 count wrap"); end
    for (int w = 0; w < 7; w++) do_read("R8 first frame");
    for (int f = 0; f < 3; f++) begin fill_random(9 + f); send_frame(9 + f, -1, "R3 count wrap"); end
    drain("R3 wrap readout");

    // R12 truncation
    fill_random(70); send_frame(70, -1, "R12 count long");
    fill_random(MAXF); send_frame(MAXF, -1, "R12 count at limit");
    fill_random(MAXF + 1); send_frame(MAXF + 1, -1, "R12 count above limit");
    drain("R12 truncated readout");

    // R10 FIFO reset with held frames and a partial read
    fill_random(30); send_frame(30, -1, "R10 count before reset");
    fill_random(30); send_frame(30, -1, "R10 count before reset");
    do_read("R10 partial read");
    pulse_fifo_rst();
    do_read("R10 read after reset");
    fill_random(17); send_frame(17, -1, "R10 count after reset");
    drain("R10 readout restarts at offset 0");

    // R10 abort mid-frame
    fill_random(20); send_frame(20, 5, "R10 aborted frame");

    // Random mix
    for (int op = 0; op < 300; op++) begin
      int sel;
      sel = $urandom_range(0, 39);
      if (sel == 0) begin
        pulse_fifo_rst();
      end else if (sel < 22) begin
        int len;
        rx_en = ($urandom_range(0, 9) != 0);
        len = $urandom_range(1, 66);
        fill_random(len);
        send_frame(len, -1, "R3 random count");
      end else begin
        int nr;
        nr = $urandom_range(1, 20);
        for (int r = 0; r < nr; r++) do_read("R7 random read");
      end
    end
    drain("R8 final drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule